// File: doc/BRIEF.md
# Byte-Stream to Word-Program Packer

This block sits in front of a programming engine that can only write whole, aligned 32-bit words. A client asks for a write by giving a byte address, a byte count and a source of bytes. The block splits the request into aligned words and fetches each source byte by its index. Where a word is only partly covered, either at the start or at the end, the block keeps the bytes that are already in memory.

Every target word is read from memory before it is programmed. The same read supplies the bytes that are kept and feeds the erase check. A programming step can only clear bits, so the new word must be a bitwise subset of the word it replaces. If it is not, the block reports the word as not erased and issues no write command. The engine answers each command with a done pulse and an error flag, and the block also limits how long it waits for that answer.

The block stops at the first error. It finishes every request with a one-cycle done pulse that carries a result code.

Top module: `bytewr_packer`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken in a cycle where both `req_valid` and `req_ready` are high, and `req_valid` has no effect while the block is busy.
- R2: A request with a byte count of zero produces `done` with code 0 in the cycle after it is accepted. It issues no memory read, no source read and no write command.
- R3: Every memory read and every write command uses a word address whose two low bits are zero. The first word is the start address with bits [1:0] cleared. Each later word is the previous word plus 4.
- R4: When the start address is misaligned, the lanes below `req_addr[1:0]` in the first word keep their existing memory bytes.
- R5: Packing is little-endian. Lane i is bits 8i+7..8i, and source bytes fill consecutive lanes in increasing index order, starting from index 0.
- R6: While at least four bytes remain, each word is built entirely from four new source bytes.
- R7: A trailing partial word takes new bytes in its low lanes and keeps the existing memory bytes in its upper lanes.
- R8: A request whose first and last byte fall in the same word produces exactly one merged write command.
- R9: If (current word AND new word) is not equal to the new word, no write command is issued for that word. The request ends with code 1 (not erased).
- R10: If `wr_err` is high together with `wr_done`, the request ends with code 2 and no later word is processed.
- R11: If `wr_done` does not arrive within ENG_TIMEOUT cycles after a write command, the request ends with code 2.
- R12: `done` is a single-cycle pulse. When every word has been written without error, the code is 0 and one write command has been issued per touched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Byte count |
| src_rd_en | output | 1 | Source byte fetch strobe |
| src_idx | output | LW | Index of the requested source byte |
| src_rd_data | input | 8 | Source byte, valid one cycle after the fetch |
| mem_rd_en | output | 1 | Memory word read strobe |
| mem_rd_addr | output | AW | Aligned word address to read |
| mem_rd_data | input | 32 | Memory word, valid one cycle after the read |
| wr_valid | output | 1 | Word write command (one-cycle pulse) |
| wr_addr | output | AW | Aligned target address |
| wr_data | output | 32 | Merged word to program |
| wr_done | input | 1 | Engine completion pulse |
| wr_err | input | 1 | Engine error, qualified by wr_done |
| done | output | 1 | Request finished (one-cycle pulse) |
| done_code | output | 2 | 0 success, 1 not erased, 2 engine error or timeout |

## Verification
An internal fault mostly becomes visible in the memory image once the request has finished. A wrong lane pointer or a wrong first-word flag leaves a bad byte next to a boundary. A wrong byte counter leaves words at the tail that were skipped or written twice. An erase-check or error-path fault shows up at `done` as a wrong code or as extra write commands. This is seen within the same request, usually at the first word that touches the affected lane. The bench therefore compares the full memory image, the number of write commands and the result code after every request.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RDW,
        ST_SRC,
        ST_CAP,
        ST_CHK,
        ST_WAIT
    } bwp_state_t;

    typedef enum logic [1:0] {
        CODE_OK         = 2'd0,
        CODE_NOT_ERASED = 2'd1,
        CODE_ENGINE     = 2'd2
    } bwp_code_t;

    typedef struct packed {
        logic [31:0] old;
        logic [31:0] data;
        logic [2:0]  lane;
        logic [2:0]  hi;
    } bwp_word_t;

    function automatic logic [31:0] put_lane(logic [31:0] w, logic [1:0] lane, logic [7:0] b);
        logic [31:0] r;
        r = w;
        r[{lane, 3'b000} +: 8] = b;
        return r;
    endfunction

endpackage

// File: rtl/bwp_lane_plan.sv
module bwp_lane_plan #(
    parameter int LW = 16
) (
    input  logic          first,
    input  logic [1:0]    off,
    input  logic [LW-1:0] remaining,
    output logic [2:0]    lo,
    output logic [2:0]    hi
);
    logic [2:0] avail;

    always_comb begin
        lo    = first ? {1'b0, off} : 3'd0;
        avail = 3'd4 - lo;
        if (remaining < LW'(avail))
            hi = lo + remaining[2:0];
        else
            hi = 3'd4;
    end
endmodule

// File: rtl/bwp_erase_chk.sv
module bwp_erase_chk (
    input  logic [31:0] cur,
    input  logic [31:0] nxt,
    output logic        ok
);
    assign ok = ((cur & nxt) == nxt);
endmodule

// File: rtl/bwp_timer.sv
module bwp_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + CW'(1);
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/bytewr_packer.sv
module bytewr_packer
    import bwp_pkg::*;
#(
    parameter int AW          = 16,
    parameter int LW          = 16,
    parameter int ENG_TIMEOUT = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic          src_rd_en,
    output logic [LW-1:0] src_idx,
    input  logic [7:0]    src_rd_data,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [31:0]   mem_rd_data,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    input  logic          wr_done,
    input  logic          wr_err,
    output logic          done,
    output logic [1:0]    done_code
);
    localparam logic [AW-1:0] WORD_STEP = AW'(4);

    bwp_state_t    state;
    bwp_word_t     wc;
    logic [AW-1:0] waddr;
    logic [1:0]    off;
    logic          first;
    logic [LW-1:0] remaining;
    logic [LW-1:0] consumed;
    logic [2:0]    plan_lo, plan_hi;
    logic          clear_ok;
    logic          tmo;

    bwp_lane_plan #(.LW(LW)) u_plan (
        .first     (first),
        .off       (off),
        .remaining (remaining),
        .lo        (plan_lo),
        .hi        (plan_hi)
    );

    bwp_erase_chk u_chk_clear (
        .cur (wc.old),
        .nxt (wc.data),
        .ok  (clear_ok)
    );

    bwp_timer #(.LIMIT(ENG_TIMEOUT)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WAIT),
        .expired (tmo)
    );

    assign req_ready   = (state == ST_IDLE);
    assign mem_rd_en   = (state == ST_RD);
    assign mem_rd_addr = waddr;
    assign src_rd_en   = (state == ST_SRC);
    assign src_idx     = consumed;
    assign wr_valid    = (state == ST_CHK) && clear_ok;
    assign wr_addr     = waddr;
    assign wr_data     = wc.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            wc        <= '0;
            waddr     <= '0;
            off       <= '0;
            first     <= 1'b0;
            remaining <= '0;
            consumed  <= '0;
            done      <= 1'b0;
            done_code <= CODE_OK;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    waddr     <= {req_addr[AW-1:2], 2'b00};
                    off       <= req_addr[1:0];
                    first     <= 1'b1;
                    remaining <= req_len;
                    consumed  <= '0;
                    if (req_len == '0) begin
                        done      <= 1'b1;
                        done_code <= CODE_OK;
                    end else begin
                        state <= ST_RD;
                    end
                end
                ST_RD:  state <= ST_RDW;
                ST_RDW: begin
                    wc.old  <= mem_rd_data;
                    wc.data <= mem_rd_data;
                    wc.lane <= plan_lo;
                    wc.hi   <= plan_hi;
                    first   <= 1'b0;
                    state   <= ST_SRC;
                end
                ST_SRC: state <= ST_CAP;
                ST_CAP: begin
                    wc.data   <= put_lane(wc.data, wc.lane[1:0], src_rd_data);
                    wc.lane   <= wc.lane + 3'd1;
                    consumed  <= consumed + LW'(1);
                    remaining <= remaining - LW'(1);
                    state     <= ((wc.lane + 3'd1) == wc.hi) ? ST_CHK : ST_SRC;
                end
                ST_CHK: begin
                    if (clear_ok) begin
                        state <= ST_WAIT;
                    end else begin
                        done      <= 1'b1;
                        done_code <= CODE_NOT_ERASED;
                        state     <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (wr_done) begin
                        if (wr_err) begin
                            done      <= 1'b1;
                            done_code <= CODE_ENGINE;
                            state     <= ST_IDLE;
                        end else if (remaining == '0) begin
                            done      <= 1'b1;
                            done_code <= CODE_OK;
                            state     <= ST_IDLE;
                        end else begin
                            waddr <= waddr + WORD_STEP;
                            state <= ST_RD;
                        end
                    end else if (tmo) begin
                        done      <= 1'b1;
                        done_code <= CODE_ENGINE;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bytewr_packer_chk.sv
module bytewr_packer_chk #(
    parameter int AW = 16,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [LW-1:0] req_len,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic [31:0]   mem_rd_data,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic [31:0]   wr_data,
    input logic          done,
    input logic [1:0]    done_code
);
    logic        rd_pend;
    logic [31:0] last_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend   <= 1'b0;
            last_word <= '0;
        end else begin
            rd_pend <= mem_rd_en;
            if (rd_pend)
                last_word <= mem_rd_data;
        end
    end

    a_r3_wr_aligned: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[1:0] == 2'b00));

    a_r3_rd_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00));

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !req_ready);

    a_r2_zero_len_done: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_len == '0) |=> (done && done_code == 2'd0));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_write_clears_only: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ((last_word & wr_data) == wr_data));

    a_r10_single_cmd: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);
endmodule

bind bytewr_packer bytewr_packer_chk #(.AW(AW), .LW(LW)) u_bwp_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_len     (req_len),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .done        (done),
    .done_code   (done_code)
);

// File: tb/bytewr_packer_bench.sv
module bytewr_packer_bench;
    localparam int AW = 16;
    localparam int LW = 16;
    localparam int TMO = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          src_rd_en;
    logic [LW-1:0] src_idx;
    logic [7:0]    src_rd_data = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_data = '0;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          wr_done = 1'b0;
    logic          wr_err = 1'b0;
    logic          done;
    logic [1:0]    done_code;

    logic [31:0] mem [64];
    logic [31:0] exp_mem [64];
    logic [7:0]  srcbuf [64];

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int src_cnt = 0;
    int inj_abs = -1;
    bit silent = 0;
    int exp_code;
    int exp_writes;

    always #5 clk = ~clk;

    bytewr_packer #(.AW(AW), .LW(LW), .ENG_TIMEOUT(TMO)) u_bytewr_packer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .src_rd_en(src_rd_en),
        .src_idx(src_idx), .src_rd_data(src_rd_data), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done), .wr_err(wr_err),
        .done(done), .done_code(done_code)
    );

    // memory and source models with one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr[7:2]];
            rd_cnt++;
        end
        if (src_rd_en) begin
            src_rd_data <= srcbuf[src_idx[5:0]];
            src_cnt++;
        end
    end

    // programming engine model
    int          eng_lat = 0;
    bit          eng_pend = 0;
    bit          eng_fail = 0;
    logic [5:0]  eng_idx = '0;
    logic [31:0] eng_dat = '0;
    always @(posedge clk) begin
        wr_done <= 1'b0;
        wr_err  <= 1'b0;
        if (wr_valid) begin
            if (!silent) begin
                eng_pend = 1;
                eng_lat  = 2;
                eng_fail = (wr_cnt == inj_abs);
                eng_idx  = wr_addr[7:2];
                eng_dat  = wr_data;
            end
            wr_cnt++;
        end else if (eng_pend) begin
            if (eng_lat == 0) begin
                eng_pend = 0;
                wr_done <= 1'b1;
                wr_err  <= eng_fail;
                if (!eng_fail) mem[eng_idx] = eng_dat;
            end else begin
                eng_lat--;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_mem(bit rand_words);
        for (int i = 0; i < 64; i++) begin
            mem[i] = 32'hFFFF_FFFF;
            if (rand_words && ($urandom_range(0, 4) == 0)) mem[i] = $urandom;
            exp_mem[i] = mem[i];
        end
    endtask

    // reference model built from the requirements
    task automatic predict(int addr, int len, int err_at, bit no_resp);
        int w, k, lane;
        logic [31:0] old, nw;
        w = addr & ~3;
        lane = addr & 3;
        k = 0;
        exp_code = 0;
        exp_writes = 0;
        while (k < len) begin
            old = exp_mem[(w >> 2) & 63];
            nw = old;
            for (int l = lane; l < 4 && k < len; l++) begin
                nw[8*l +: 8] = srcbuf[k];
                k++;
            end
            lane = 0;
            if ((old & nw) != nw) begin exp_code = 1; break; end
            exp_writes++;
            if (no_resp || exp_writes - 1 == err_at) begin exp_code = 2; break; end
            exp_mem[(w >> 2) & 63] = nw;
            w += 4;
        end
    endtask

    task automatic run(string req, int addr, int len, int err_at, bit no_resp);
        int w0, r0, s0, code, seen, lat;
        bit same;
        predict(addr, len, err_at, no_resp);
        silent = no_resp;
        w0 = wr_cnt;
        r0 = rd_cnt;
        s0 = src_cnt;
        inj_abs = (err_at < 0) ? -1 : w0 + err_at;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = AW'(addr);
        req_len = LW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0;
        code = -1;
        lat = 0;
        for (int c = 0; c < 3000 && !seen; c++) begin
            if (done) begin
                seen = 1;
                code = done_code;
                lat = c;
            end else begin
                @(negedge clk);
            end
        end
        check({req, " done seen"}, seen, 1);
        check({req, " code"}, code, exp_code);
        check({req, " write count"}, wr_cnt - w0, exp_writes);
        same = 1;
        for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) same = 0;
        check({req, " memory image"}, same, 1);
        if (len == 0) begin
            check("R2 done latency", lat, 0);
            check("R2 no reads", (rd_cnt - r0) + (src_cnt - s0), 0);
        end
        @(negedge clk);
        silent = 0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        fill_mem(0);
        for (int i = 0; i < 64; i++) srcbuf[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset ready", req_ready, 1);
        check("R12 reset done", done, 0);
        check("R3 reset no write", wr_valid, 0);

        run("R2 zero length", 5, 0, -1, 0);
        run("R6 aligned words", 16, 8, -1, 0);
        run("R4 head merge", 33, 6, -1, 0);
        check("R4 low lane kept", mem[8][7:0], 8'hFF);

        fill_mem(0);
        mem[12] = 32'h12FF_FF34; exp_mem[12] = mem[12];
        run("R8 single word", 49, 2, -1, 0);
        check("R5 lane order", mem[12], {8'h12, srcbuf[1], srcbuf[0], 8'h34});

        fill_mem(0);
        mem[21] = 32'hA5C3_FFFF; exp_mem[21] = mem[21];
        run("R7 tail merge", 80, 6, -1, 0);
        check("R7 upper lanes kept", mem[21][31:16], 16'hA5C3);

        fill_mem(0);
        mem[17] = 32'h0; exp_mem[17] = 0;
        run("R9 not erased", 64, 8, -1, 0);

        fill_mem(0);
        run("R10 engine error", 96, 12, 1, 0);
        fill_mem(0);
        run("R11 timeout", 128, 4, -1, 1);

        for (int t = 0; t < 40; t++) begin
            int a, l, e;
            fill_mem(t % 2 == 1);
            for (int i = 0; i < 64; i++) srcbuf[i] = 8'($urandom);
            l = $urandom_range(0, 40);
            a = $urandom_range(0, 250 - l);
            e = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 3) : -1;
            run("R12 random", a, l, e, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule